// File: doc/BRIEF.md
# Square-Wave Interval Timer Channel

This block is one channel of a programmable interval timer, set up to make a symmetric square wave. Typical uses are a periodic interrupt line and a tone output. A 16-bit divisor is presented with a one-cycle load strobe. The channel advances only on cycles where the tick enable is high, so it counts at the timer tick rate while sitting in a faster clock domain. Its single output repeats with a full period of divisor × tick period, which gives an output frequency equal to the tick frequency divided by the divisor.

Internally the count register is preloaded with a value and steps down by two on each tick. When it reaches its terminal value, the output flips and the register is reloaded, so each half-period is a separate count. An odd divisor is handled by loading one more for the high half and one less for the low half. A gate input pauses the channel and holds its output high. Raising the gate restarts the waveform from a fresh high half.

Top module: `sqwave_timer_chan`

## Requirements
- R1: After reset, and until a divisor has been written and loaded, `waveOut` is 1, whatever ticks arrive.
- R2: A written divisor is loaded on the first tick that comes strictly after the cycle of `loadStb`. A tick in the same cycle as the strobe does not load. The load tick starts a high half-period.
- R3: For an even divisor N, `waveOut` is high for N/2 ticks, then low for N/2 ticks, and this repeats indefinitely.
- R4: For an odd divisor N ≥ 3, the high half lasts (N+1)/2 ticks and the low half lasts (N-1)/2 ticks.
- R5: A divisor of 0 is taken as 65536, which gives 32768 ticks high and 32768 ticks low.
- R6: A divisor of 1 gives one tick high and one tick low.
- R7: The channel changes state only on cycles with `tickEn` = 1. With no tick, `waveOut` holds its level for any number of clock cycles.
- R8: While `gate` is 0, `waveOut` is 1 in the same cycle and counting is suspended.
- R9: After `gate` returns to 1, the first tick reloads the divisor and starts a full high half-period.
- R10: A divisor written while the channel is running does not shorten the half-period in progress. It is first used at the next half-period reload.
- R11: The internal count is always even and, on a tick that is not a reload, it drops by exactly two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter tick enable, one cycle per timer tick |
| loadStb | input | 1 | One-cycle strobe that captures `countIn` as the divisor |
| countIn | input | 16 | Divisor value; 0 means 65536 |
| gate | input | 1 | Run enable; 0 pauses the channel and forces the output high |
| waveOut | output | 1 | Square-wave output |

## Verification
The embedded properties check these rules on every cycle:
- the count stays even and steps down by two;
- the output level holds between ticks;
- the level flips whenever the count hits its terminal value with a tick;
- the output is high while idle, while the gate is low and after a restart.

Only the directed scenarios can show the actual half-period lengths. Those scenarios cover even, odd, 1 and 0 divisors, the one-tick load delay, and the pause and restart around the gate. They also show that a mid-run rewrite waits for the next reload, because that depends on whole sequences of ticks, not on one cycle.

// File: rtl/sqwave_pkg.sv
package sqwave_pkg;

  // Strobes from the control half to the datapath half, valid for one cycle
  typedef struct packed {
    logic doStart;   // load the divisor for a fresh high half-period
    logic doWrap;    // terminal count reached: reload for the next half
    logic doStep;    // ordinary tick: step the count down by two
    logic newLevel;  // output level that the reload is being made for
  } chanStb_t;

endpackage

// File: rtl/sqwave_datapath.sv
module sqwave_datapath
  import sqwave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             loadStb,
  input  logic [CNT_W-1:0] countIn,
  input  chanStb_t         stb,
  output logic             atTerm
);

  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(1) << CNT_W;
  localparam logic [CW-1:0] TERM_CNT = CW'(2);

  logic [CNT_W-1:0] holdCount;
  logic [CW-1:0]    counter;
  logic [CW-1:0]    extCount;
  logic [CW-1:0]    reloadVal;

  // Divisor register: a write during a run is only picked up at a reload
  always_ff @(posedge clk) begin
    if (!rst_n)       holdCount <= '0;
    else if (loadStb) holdCount <= countIn;
  end

  // Reload value per half-period: zero means full range; odd counts split unevenly
  always_comb begin
    extCount = (holdCount == '0) ? FULL_CNT : {1'b0, holdCount};
    if (!extCount[0])       reloadVal = extCount;
    else if (stb.newLevel)  reloadVal = extCount + CW'(1);
    else if (extCount == CW'(1)) reloadVal = TERM_CNT;
    else                    reloadVal = extCount - CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        counter <= '0;
    else if (stb.doStart || stb.doWrap) counter <= reloadVal;
    else if (stb.doStep)               counter <= counter - CW'(2);
  end

  assign atTerm = (counter == TERM_CNT);

  // R11: the count never becomes odd
  a_r11_count_even: assert property (@(posedge clk) disable iff (!rst_n)
    counter[0] == 1'b0)
    else $error("a_r11_count_even");

  // R11: an ordinary tick removes exactly two
  a_r11_step_two: assert property (@(posedge clk) disable iff (!rst_n)
    stb.doStep |=> (counter == $past(counter) - CW'(2)))
    else $error("a_r11_step_two");

  // R5: a fresh load lands inside the legal range
  a_r5_load_range: assert property (@(posedge clk) disable iff (!rst_n)
    stb.doStart |=> (counter >= TERM_CNT && counter <= FULL_CNT))
    else $error("a_r5_load_range");

endmodule

// File: rtl/sqwave_ctrl.sv
module sqwave_ctrl
  import sqwave_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tickEn,
  input  logic     loadStb,
  input  logic     gate,
  input  logic     atTerm,
  output chanStb_t stb,
  output logic     outLevel
);

  logic armed;     // a divisor has been written since reset
  logic startReq;  // next live tick must load a fresh high half
  logic tickLive;

  assign tickLive = tickEn && gate && armed;

  always_comb begin
    stb = '0;
    if (tickLive && startReq) begin
      stb.doStart  = 1'b1;
      stb.newLevel = 1'b1;
    end else if (tickLive) begin
      if (atTerm) begin
        stb.doWrap   = 1'b1;
        stb.newLevel = ~outLevel;
      end else begin
        stb.doStep = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      startReq <= 1'b0;
      outLevel <= 1'b1;
    end else begin
      if (loadStb && !armed) begin
        armed    <= 1'b1;
        startReq <= 1'b1;
      end
      if (!gate && (armed || loadStb)) startReq <= 1'b1;
      if (stb.doStart) startReq <= 1'b0;
      if (!gate)                          outLevel <= 1'b1;
      else if (stb.doStart || stb.doWrap) outLevel <= stb.newLevel;
    end
  end

  // R1: idle channel stays high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> outLevel)
    else $error("a_r1_idle_high");

  // R7: without a tick the level holds
  a_r7_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!tickEn && gate) |=> $stable(outLevel))
    else $error("a_r7_hold_no_tick");

  // R3: terminal count with a tick flips the level
  a_r3_flip_at_term: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && gate && armed && !startReq && atTerm) |=> (outLevel != $past(outLevel)))
    else $error("a_r3_flip_at_term");

  // R8: gate low drives the level high
  a_r8_gate_high: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> outLevel)
    else $error("a_r8_gate_high");

  // R9: a restart begins with a high half
  a_r9_restart_high: assert property (@(posedge clk) disable iff (!rst_n)
    (tickEn && gate && startReq) |=> outLevel)
    else $error("a_r9_restart_high");

endmodule

// File: rtl/sqwave_timer_chan.sv
module sqwave_timer_chan
  import sqwave_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tickEn,
  input  logic             loadStb,
  input  logic [CNT_W-1:0] countIn,
  input  logic             gate,
  output logic             waveOut
);

  chanStb_t stb;
  logic     atTerm;
  logic     outLevel;

  sqwave_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tickEn   (tickEn),
    .loadStb  (loadStb),
    .gate     (gate),
    .atTerm   (atTerm),
    .stb      (stb),
    .outLevel (outLevel)
  );

  sqwave_datapath #(.CNT_W(CNT_W)) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .loadStb (loadStb),
    .countIn (countIn),
    .stb     (stb),
    .atTerm  (atTerm)
  );

  // Gate low forces the output high in the same cycle (R8)
  assign waveOut = outLevel | ~gate;

  // R8: output high whenever gate is low
  a_r8_out_forced: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) |-> waveOut)
    else $error("a_r8_out_forced");

endmodule

// File: tb/sqwave_timer_chan_tb_top.sv
module sqwave_timer_chan_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tickEn = 1'b0;
  logic        loadStb = 1'b0;
  logic [15:0] countIn = '0;
  logic        gate = 1'b1;
  logic        waveOut;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  sqwave_timer_chan dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tickEn  (tickEn),
    .loadStb (loadStb),
    .countIn (countIn),
    .gate    (gate),
    .waveOut (waveOut)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0; tickEn = 1'b0; loadStb = 1'b0; gate = 1'b1; countIn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic writeCount(input logic [15:0] n);
    @(negedge clk);
    countIn = n; loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
  endtask

  // One tick, then sample the output at the following falling edge
  task automatic tick(output logic s);
    @(negedge clk);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
    s = waveOut;
  endtask

  task automatic collectRuns(input int nRuns, input int cap, output logic firstLvl,
                             output int r0, output int r1, output int r2);
    logic s, prev;
    int cnt, idx;
    int runs[3];
    runs = '{0, 0, 0};
    tick(s);
    firstLvl = s; prev = s; cnt = 1; idx = 0;
    for (int i = 0; i < cap && idx < nRuns; i++) begin
      tick(s);
      if (s == prev) cnt++;
      else begin
        runs[idx] = cnt; idx++; cnt = 1; prev = s;
      end
    end
    r0 = runs[0]; r1 = runs[1]; r2 = runs[2];
  endtask

  task automatic waveTest(input string req, input logic [15:0] n,
                          input int expH, input int expL, input int nRuns, input int cap);
    logic f; int r0, r1, r2;
    doReset();
    writeCount(n);
    collectRuns(nRuns, cap, f, r0, r1, r2);
    chk(req, "first level", int'(f), 1);
    chk(req, "high run", r0, expH);
    chk(req, "low run", r1, expL);
    if (nRuns > 2) chk(req, "second high run", r2, expH);
  endtask

  task automatic testReset();
    logic s;
    doReset();
    chk("R1", "out after reset", int'(waveOut), 1);
    for (int i = 0; i < 5; i++) begin
      tick(s);
      chk("R1", "out idle tick", int'(s), 1);
    end
  endtask

  task automatic testSameCycleTick();
    logic f, s; int r0, r1, r2;
    doReset();
    @(negedge clk);
    countIn = 16'd4; loadStb = 1'b1; tickEn = 1'b1;
    @(negedge clk);
    loadStb = 1'b0; tickEn = 1'b0;
    s = waveOut;
    chk("R2", "out after strobe tick", int'(s), 1);
    collectRuns(2, 50, f, r0, r1, r2);
    chk("R2", "high run after load", r0, 2);
    chk("R2", "low run", r1, 2);
  endtask

  task automatic testNoTick();
    logic s;
    doReset();
    writeCount(16'd4);
    tick(s); tick(s); tick(s);
    chk("R7", "low after three ticks", int'(s), 0);
    repeat (20) begin
      @(negedge clk);
      chk("R7", "hold without tick", int'(waveOut), 0);
    end
    tick(s);
    chk("R7", "second low tick", int'(s), 0);
    tick(s);
    chk("R7", "back high", int'(s), 1);
  endtask

  task automatic testGate();
    logic s, f; int r0, r1, r2;
    doReset();
    writeCount(16'd8);
    for (int i = 0; i < 6; i++) tick(s);
    chk("R8", "low before gate", int'(s), 0);
    @(negedge clk);
    gate = 1'b0;
    #1;
    chk("R8", "forced high same cycle", int'(waveOut), 1);
    for (int i = 0; i < 3; i++) begin
      tick(s);
      chk("R8", "high while gated", int'(s), 1);
    end
    @(negedge clk);
    gate = 1'b1;
    collectRuns(3, 50, f, r0, r1, r2);
    chk("R9", "restart level", int'(f), 1);
    chk("R9", "full high after restart", r0, 4);
    chk("R9", "low after restart", r1, 4);
    chk("R9", "high again", r2, 4);
  endtask

  task automatic testRewrite();
    logic s, f; int r0, r1, r2;
    doReset();
    writeCount(16'd10);
    for (int i = 0; i < 3; i++) tick(s);
    writeCount(16'd6);
    collectRuns(3, 50, f, r0, r1, r2);
    chk("R10", "rest of old high half", r0, 2);
    chk("R10", "new low half", r1, 3);
    chk("R10", "new high half", r2, 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testSameCycleTick();
    waveTest("R3", 16'd10, 5, 5, 3, 100);
    waveTest("R4", 16'd7, 4, 3, 3, 100);
    waveTest("R4", 16'd3, 2, 1, 3, 100);
    waveTest("R6", 16'd1, 1, 1, 3, 100);
    testNoTick();
    testGate();
    testRewrite();
    waveTest("R5", 16'd0, 32768, 32768, 2, 70000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule